// File: doc/BRIEF.md
# Two-Port Handshaked Parallel I/O Data Path

This block carries bytes between a processor's register port and two 8-line parallel ports, A and B. Each port has its own strobe input and ready output. A mode request for each port comes from a separate configuration block. The supported modes are:

- **Input:** latched byte capture.
- **Output:** latched byte drive.
- **Bidirectional:** port A only.
- **Bit-programmable:** each line takes its direction from its own mask bit.

Pins appear in split form: input, output and output-enable vectors. A pad ring or an outer level of the hierarchy builds the three-state buffers.

In bidirectional mode, port A's strobe and ready lines handle the incoming byte. Port B's strobe and ready lines handle the outgoing byte of port A. For this reason port A may enter that mode only once port B already sits in bit-programmable mode. While port A stays bidirectional, port B is held in bit-programmable mode.

Top module: `dual_port_pio`

## Requirements
- R1: Mode requests are encoded 2'b00 input, 2'b01 output, 2'b10 bidirectional, 2'b11 bit-programmable. An accepted request becomes the port's mode at the next clock edge.
- R2: In input mode, a strobe falling edge captures the pin byte into the port latch at the clock edge that first samples the strobe low after a high sample. The same edge sets the port's full flag (stat_full bit 0 = A, bit 1 = B). A processor read of the port returns the captured byte.
- R3: In input mode, a processor read clears the full flag at the next edge. A strobe capture in the same cycle as a read wins and leaves the flag set, holding the new byte.
- R4: In input mode, ready is high while the latch is empty and low while it holds an unread byte. The port's output enables are all zero.
- R5: In output mode, a processor write loads the output latch at the next edge. That edge raises ready and clears the empty flag (stat_empty bit 0 = A, bit 1 = B). The pins drive the latch with all enables set.
- R6: In output mode, a strobe falling edge while ready is high drops ready and sets the empty flag at that edge.
- R7: A bidirectional request on port B is ignored, and port B keeps its current mode.
- R8: A bidirectional request on port A is accepted only if port B is already in bit-programmable mode and stays there. Otherwise port A keeps its current mode. While port A is bidirectional, port B requests other than bit-programmable are ignored.
- R9: In bidirectional mode, port A's strobe and ready handle capture as in input mode. A write to port A raises b_rdy, and a falling edge on b_stb_n drops b_rdy and sets port A's empty flag.
- R10: In bidirectional mode, all of pa_oe is one while b_stb_n is low and zero while it is high, with no clock delay.
- R11: In bit-programmable mode, the output enables equal the direction mask (1 = output), the pins drive the last written byte, and ready is low. A read returns the pin value on lines whose mask bit is 0 and the latch value on lines whose mask bit is 1.
- R12: While rst_n is low, both ports are in input mode, both ready outputs are low, and all status flags are zero. Any mode change also clears that port's flags and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_a_req | input | 2 | Requested mode for port A |
| mode_b_req | input | 2 | Requested mode for port B |
| dir_a | input | W | Per-line direction mask for port A (1 = output) |
| dir_b | input | W | Per-line direction mask for port B (1 = output) |
| cpu_sel | input | 1 | Port select for register access (0 = A, 1 = B) |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | W | Write data |
| cpu_rdata | output | W | Read data of the selected port |
| pa_in | input | W | Port A pin input values |
| pa_out | output | W | Port A pin output values |
| pa_oe | output | W | Port A per-line output enables |
| pb_in | input | W | Port B pin input values |
| pb_out | output | W | Port B pin output values |
| pb_oe | output | W | Port B per-line output enables |
| a_stb_n | input | 1 | Port A strobe, active low |
| a_rdy | output | 1 | Port A ready |
| b_stb_n | input | 1 | Port B strobe, active low |
| b_rdy | output | 1 | Port B ready |
| stat_full | output | 2 | Input latch full flags (bit 0 = A) |
| stat_empty | output | 2 | Output latch acknowledged flags (bit 0 = A) |

## Verification
Every one of the 256 byte values passes through port A's input capture, and then through port B's output handshake. This tells a correct latch from one that drops or swaps bits. A strobe that coincides with a read separates capture priority from clear priority. Bit-programmable mode is swept over sixteen direction masks, with pin and latch values that are complements of each other, so each read bit shows which source it came from. Legal and illegal bidirectional requests, and a port B change attempted during bidirectional mode, show whether the mode interlock holds.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PM_IN    = 2'b00,
    PM_OUT   = 2'b01,
    PM_BIDIR = 2'b10,
    PM_BITS  = 2'b11
  } pio_mode_e;
endpackage

// File: rtl/pio_mode_ctl.sv
module pio_mode_ctl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_a,
  input  logic [1:0] req_b,
  output pio_mode_e  mode_a,
  output pio_mode_e  mode_b,
  output logic       chg_a,
  output logic       chg_b
);
  pio_mode_e nxt_a, nxt_b;

  always_comb begin
    nxt_b = pio_mode_e'(req_b);
    // port B never goes bidirectional
    if (nxt_b == PM_BIDIR) nxt_b = mode_b;
    // port B is pinned to bit mode while A owns its handshake
    if ((mode_a == PM_BIDIR) && (nxt_b != PM_BITS)) nxt_b = mode_b;
    nxt_a = pio_mode_e'(req_a);
    if ((nxt_a == PM_BIDIR) && !((mode_b == PM_BITS) && (nxt_b == PM_BITS)))
      nxt_a = mode_a;
  end

  assign chg_a = (nxt_a != mode_a);
  assign chg_b = (nxt_b != mode_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a <= PM_IN;
      mode_b <= PM_IN;
    end else begin
      mode_a <= nxt_a;
      mode_b <= nxt_b;
    end
  end
endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '1;
    else        lvl_q <= lvl_n;
  end

  assign fall = lvl_q & ~lvl_n;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_en,
  input  logic         out_en,
  input  logic         ld_en,
  input  logic         cap_fall,
  input  logic         ack_fall,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] in_q,
  output logic [W-1:0] out_q,
  output logic         full,
  output logic         empty,
  output logic         in_rdy,
  output logic         out_rdy
);
  logic [W-1:0] in_d, out_d;
  logic         full_d, empty_d, in_rdy_d, out_rdy_d;
  logic         cap, load, ack;

  assign cap  = in_en & cap_fall;
  assign load = out_en & wr_hit;
  assign ack  = out_en & ack_fall & out_rdy;

  always_comb begin
    in_d      = in_q;
    out_d     = out_q;
    full_d    = full;
    empty_d   = empty;
    out_rdy_d = out_rdy;
    if (cap)                   in_d  = pin_in;
    if (ld_en && wr_hit)       out_d = wdata;
    if (clr)                   full_d = 1'b0;
    else if (cap)              full_d = 1'b1;
    else if (rd_hit && in_en)  full_d = 1'b0;
    if (clr) begin
      empty_d   = 1'b0;
      out_rdy_d = 1'b0;
    end else if (load) begin
      empty_d   = 1'b0;
      out_rdy_d = 1'b1;
    end else if (ack) begin
      empty_d   = 1'b1;
      out_rdy_d = 1'b0;
    end
    in_rdy_d = in_en & ~full_d & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      out_q   <= '0;
      full    <= 1'b0;
      empty   <= 1'b0;
      in_rdy  <= 1'b0;
      out_rdy <= 1'b0;
    end else begin
      in_q    <= in_d;
      out_q   <= out_d;
      full    <= full_d;
      empty   <= empty_d;
      in_rdy  <= in_rdy_d;
      out_rdy <= out_rdy_d;
    end
  end
endmodule

// File: rtl/dual_port_pio.sv
module dual_port_pio
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_a_req,
  input  logic [1:0]   mode_b_req,
  input  logic [W-1:0] dir_a,
  input  logic [W-1:0] dir_b,
  input  logic         cpu_sel,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic         a_stb_n,
  output logic         a_rdy,
  input  logic         b_stb_n,
  output logic         b_rdy,
  output logic [1:0]   stat_full,
  output logic [1:0]   stat_empty
);
  localparam int NPORT = 2;

  pio_mode_e mode_a_q, mode_b_q;
  logic      clr_a, clr_b;
  logic [NPORT-1:0] stb_fall;
  logic      a_fall, b_fall;

  pio_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .req_a(mode_a_req), .req_b(mode_b_req),
    .mode_a(mode_a_q), .mode_b(mode_b_q), .chg_a(clr_a), .chg_b(clr_b)
  );

  pio_edge #(.N(NPORT)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_n({b_stb_n, a_stb_n}), .fall(stb_fall)
  );
  assign a_fall = stb_fall[0];
  assign b_fall = stb_fall[1];

  logic [NPORT-1:0] is_in, is_out, is_bits, in_en, out_en, ld_en;
  logic             a_bidir;
  assign a_bidir = (mode_a_q == PM_BIDIR);

  // per-port mode decode
  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    pio_mode_e m;
    assign m          = (p == 0) ? mode_a_q : mode_b_q;
    assign is_in[p]   = (m == PM_IN);
    assign is_out[p]  = (m == PM_OUT);
    assign is_bits[p] = (m == PM_BITS);
    assign in_en[p]   = is_in[p]  | ((p == 0) && (m == PM_BIDIR));
    assign out_en[p]  = is_out[p] | ((p == 0) && (m == PM_BIDIR));
    assign ld_en[p]   = out_en[p] | is_bits[p];
  end

  logic [W-1:0] a_in_q, a_out_q, b_in_q, b_out_q;
  logic a_full, a_empty, a_in_rdy, a_out_rdy;
  logic b_full, b_empty, b_in_rdy, b_out_rdy;
  logic rd_a, wr_a, rd_b, wr_b, a_ack;

  assign rd_a  = cpu_rd & ~cpu_sel;
  assign wr_a  = cpu_wr & ~cpu_sel;
  assign rd_b  = cpu_rd &  cpu_sel;
  assign wr_b  = cpu_wr &  cpu_sel;
  assign a_ack = a_bidir ? b_fall : a_fall;

  pio_port #(.W(W)) u_port_a (
    .clk(clk), .rst_n(rst_n), .clr(clr_a),
    .in_en(in_en[0]), .out_en(out_en[0]), .ld_en(ld_en[0]),
    .cap_fall(a_fall), .ack_fall(a_ack), .rd_hit(rd_a), .wr_hit(wr_a),
    .wdata(cpu_wdata), .pin_in(pa_in), .in_q(a_in_q), .out_q(a_out_q),
    .full(a_full), .empty(a_empty), .in_rdy(a_in_rdy), .out_rdy(a_out_rdy)
  );

  pio_port #(.W(W)) u_port_b (
    .clk(clk), .rst_n(rst_n), .clr(clr_b),
    .in_en(in_en[1]), .out_en(out_en[1]), .ld_en(ld_en[1]),
    .cap_fall(b_fall), .ack_fall(b_fall), .rd_hit(rd_b), .wr_hit(wr_b),
    .wdata(cpu_wdata), .pin_in(pb_in), .in_q(b_in_q), .out_q(b_out_q),
    .full(b_full), .empty(b_empty), .in_rdy(b_in_rdy), .out_rdy(b_out_rdy)
  );

  function automatic logic [W-1:0] rd_mux(input pio_mode_e m, input logic [W-1:0] iq,
                                          input logic [W-1:0] oq, input logic [W-1:0] pin,
                                          input logic [W-1:0] dir);
    case (m)
      PM_OUT:  return oq;
      PM_BITS: return (pin & ~dir) | (oq & dir);
      default: return iq;
    endcase
  endfunction

  always_comb begin
    if (cpu_sel) cpu_rdata = rd_mux(mode_b_q, b_in_q, b_out_q, pb_in, dir_b);
    else         cpu_rdata = rd_mux(mode_a_q, a_in_q, a_out_q, pa_in, dir_a);
  end

  // pin drive
  always_comb begin
    case (mode_a_q)
      PM_OUT:   pa_oe = '1;
      PM_BITS:  pa_oe = dir_a;
      PM_BIDIR: pa_oe = {W{~b_stb_n}};
      default:  pa_oe = '0;
    endcase
    case (mode_b_q)
      PM_OUT:  pb_oe = '1;
      PM_BITS: pb_oe = dir_b;
      default: pb_oe = '0;
    endcase
  end
  assign pa_out = a_out_q;
  assign pb_out = b_out_q;

  // handshake routing: in bidirectional mode A's output ready moves to B's pin
  assign a_rdy = a_in_rdy | (a_out_rdy & ~a_bidir);
  assign b_rdy = b_in_rdy | b_out_rdy | (a_out_rdy & a_bidir);

  assign stat_full  = {b_full, a_full};
  assign stat_empty = {b_empty, a_empty};
endmodule

// File: rtl/pio_checker.sv
module pio_checker
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input pio_mode_e    mode_a,
  input pio_mode_e    mode_b,
  input logic         clr_a,
  input logic         clr_b,
  input logic         a_fall,
  input logic         b_fall,
  input logic         cpu_sel,
  input logic         cpu_wr,
  input logic         a_rdy,
  input logic         b_rdy,
  input logic         b_stb_n,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_oe,
  input logic [1:0]   stat_full,
  input logic [1:0]   stat_empty
);
  AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == PM_IN && a_fall && !clr_a) |=> (stat_full[0] && !a_rdy)); // R2

  AST_IN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == PM_IN) |-> (pb_oe == '0)); // R4

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == PM_OUT && cpu_wr && !cpu_sel && !clr_a) |=> (a_rdy && !stat_empty[0])); // R5

  AST_OUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == PM_OUT && b_rdy && b_fall && !(cpu_wr && cpu_sel) && !clr_b)
      |=> (!b_rdy && stat_empty[1])); // R6

  AST_BIDIR_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == PM_BIDIR) |-> (mode_b == PM_BITS)); // R8

  AST_BIDIR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == PM_BIDIR && b_stb_n) |-> (pa_oe == '0)); // R10

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_CLEAR_QUIET: assert (!a_rdy && !b_rdy && stat_full == 2'b00 && stat_empty == 2'b00); // R12
    end
  end
endmodule

bind dual_port_pio pio_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_a(mode_a_q), .mode_b(mode_b_q),
  .clr_a(clr_a), .clr_b(clr_b), .a_fall(a_fall), .b_fall(b_fall),
  .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .a_rdy(a_rdy), .b_rdy(b_rdy),
  .b_stb_n(b_stb_n), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .stat_full(stat_full), .stat_empty(stat_empty)
);

// File: tb/tb_dual_port_pio.sv
`timescale 1ns/1ps
module tb_dual_port_pio;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_a_req, mode_b_req;
  logic [7:0] dir_a, dir_b, cpu_wdata, cpu_rdata;
  logic       cpu_sel, cpu_wr, cpu_rd;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic       a_stb_n, a_rdy, b_stb_n, b_rdy;
  logic [1:0] stat_full, stat_empty;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_port_pio dut (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; mode_a_req = 2'b00; mode_b_req = 2'b00;
    dir_a = '0; dir_b = '0; cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cpu_wdata = '0; pa_in = '0; pb_in = '0; a_stb_n = 1'b1; b_stb_n = 1'b1;
    repeat (3) tick();
    chk("R12 a_rdy in clear", 32'(a_rdy), 0);
    chk("R12 b_rdy in clear", 32'(b_rdy), 0);
    chk("R12 oe in clear", {16'h0, pa_oe, pb_oe}, 0);
    chk("R12 status in clear", {28'h0, stat_full, stat_empty}, 0);
    rst_n = 1'b1;
    tick();
    chk("R4 a_rdy empty", 32'(a_rdy), 1);
    chk("R4 b_rdy empty", 32'(b_rdy), 1);

    // R2/R3/R4: every byte through port A input
    for (int v = 0; v < 256; v++) begin
      pa_in = 8'(v); a_stb_n = 1'b0;
      tick();
      chk("R2 full A", 32'(stat_full[0]), 1);
      chk("R4 rdy low when full", 32'(a_rdy), 0);
      chk("R2 data A", 32'(cpu_rdata), 32'(v));
      a_stb_n = 1'b1; cpu_rd = 1'b1;
      tick();
      cpu_rd = 1'b0;
      chk("R3 read clears", 32'(stat_full[0]), 0);
      chk("R4 rdy back", 32'(a_rdy), 1);
    end
    chk("R4 pa_oe input", 32'(pa_oe), 0);

    // R3: capture with simultaneous read
    pa_in = 8'h3C; a_stb_n = 1'b0; tick(); a_stb_n = 1'b1; tick();
    pa_in = 8'hC3; a_stb_n = 1'b0; cpu_rd = 1'b1; tick();
    cpu_rd = 1'b0; a_stb_n = 1'b1;
    chk("R3 capture wins flag", 32'(stat_full[0]), 1);
    chk("R3 capture wins data", 32'(cpu_rdata), 32'h C3);
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;

    // R2 on port B
    cpu_sel = 1'b1;
    for (int v = 1; v < 256; v = v * 2 + 1) begin
      pb_in = 8'(v); b_stb_n = 1'b0; tick(); b_stb_n = 1'b1;
      chk("R2 data B", 32'(cpu_rdata), 32'(v));
      chk("R2 full B", 32'(stat_full[1]), 1);
      cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
    end

    // R1/R5/R6: port B output
    mode_b_req = 2'b01; tick();
    chk("R1 B output applied", 32'(pb_oe), 32'h FF);
    chk("R12 change clears", {30'h0, stat_empty[1], b_rdy}, 0);
    for (int v = 0; v < 256; v++) begin
      cpu_wdata = 8'(v); cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
      chk("R5 pb_out", 32'(pb_out), 32'(v));
      chk("R5 rdy up", 32'(b_rdy), 1);
      chk("R5 empty low", 32'(stat_empty[1]), 0);
      b_stb_n = 1'b0; tick(); b_stb_n = 1'b1;
      chk("R6 rdy down", 32'(b_rdy), 0);
      chk("R6 empty set", 32'(stat_empty[1]), 1);
      tick();
    end

    // R7: B bidirectional ignored
    mode_b_req = 2'b10; tick(); tick();
    chk("R7 B stays output", 32'(pb_oe), 32'h FF);
    cpu_wdata = 8'h5A; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
    chk("R7 B still handshakes", 32'(b_rdy), 1);

    // R8: A bidirectional refused while B not in bit mode
    mode_b_req = 2'b01; mode_a_req = 2'b10; tick();
    b_stb_n = 1'b0; #1;
    chk("R8 refused no drive", 32'(pa_oe), 0);
    tick(); b_stb_n = 1'b1;
    chk("R8 A still input", 32'(a_rdy), 1);
    mode_a_req = 2'b00; tick();

    // R11: bit-programmable sweep on B
    mode_b_req = 2'b11; tick();
    chk("R11 bit mode rdy low", 32'(b_rdy), 0);
    cpu_sel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d, v, p;
      d = 8'(i * 17) ^ 8'(i << 1);
      v = 8'(i * 29 + 7);
      p = ~v;
      dir_b = d; pb_in = p; cpu_wdata = v; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
      chk("R11 oe mask", 32'(pb_oe), 32'(d));
      chk("R11 pins", 32'(pb_out), 32'(v));
      chk("R11 read mix", 32'(cpu_rdata), 32'((p & ~d) | (v & d)));
    end
    dir_b = 8'h96;

    // R8/R9/R10: A bidirectional with B in bit mode
    cpu_sel = 1'b0; mode_a_req = 2'b10; tick();
    chk("R10 idle no drive", 32'(pa_oe), 0);
    cpu_wdata = 8'hE7; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
    chk("R9 b_rdy out side", 32'(b_rdy), 1);
    chk("R9 a_rdy input side", 32'(a_rdy), 1);
    b_stb_n = 1'b0; #1;
    chk("R10 drive on strobe", 32'(pa_oe), 32'h FF);
    chk("R10 pins", 32'(pa_out), 32'h E7);
    tick();
    chk("R9 ack drops b_rdy", 32'(b_rdy), 0);
    chk("R9 ack sets empty", 32'(stat_empty[0]), 1);
    b_stb_n = 1'b1; #1;
    chk("R10 release", 32'(pa_oe), 0);
    tick();
    pa_in = 8'h81; a_stb_n = 1'b0; tick(); a_stb_n = 1'b1;
    chk("R9 capture", 32'(cpu_rdata), 32'h81);
    chk("R9 a_rdy low", 32'(a_rdy), 0);
    cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
    chk("R9 read clears", 32'(stat_full[0]), 0);
    mode_b_req = 2'b01; tick(); tick();
    chk("R8 B held in bit mode", 32'(pb_oe), 32'h 96);

    // R12: clear in the middle of output activity
    mode_b_req = 2'b11; mode_a_req = 2'b01; tick();
    cpu_wdata = 8'h42; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
    chk("R5 A output rdy", 32'(a_rdy), 1);
    mode_a_req = 2'b00; mode_b_req = 2'b00;
    rst_n = 1'b0; #1;
    chk("R12 clear rdy", {30'h0, a_rdy, b_rdy}, 0);
    chk("R12 clear to input", {16'h0, pa_oe, pb_oe}, 0);
    chk("R12 clear status", {28'h0, stat_full, stat_empty}, 0);
    tick(); rst_n = 1'b1; tick();
    chk("R12 input after clear", 32'(a_rdy), 1);

    done = 1'b1;
    summary();
  end
endmodule